// File: doc/BRIEF.md
# Color Lookup Table with Sequenced Register Loading

This block holds a color lookup table of 256 entries. Each entry carries an 8-bit red, an 8-bit green and an 8-bit blue component. A pixel pipeline presents an 8-bit pixel code on the lookup port every cycle. One cycle later it receives the 24-bit color stored for that code.

Software programs the table through a 16-byte window of 32-bit registers. A write to the pointer register selects an entry. Three writes to the component register then load that entry's red, green and blue in that fixed order. A hidden phase counter steers each write to the right component. After the blue write the pointer moves on to the next entry by itself, so a run of entries can be streamed without rewriting the pointer.

Every component write raises a one-cycle change pulse, which downstream refresh logic can use to repaint the screen. Register reads always return zero.

Top module: `palette_dac`

## Requirements
- R1: After reset, entries 0 to 254 hold {0,0,0} and entry 255 holds {255,255,255}. The pointer is 0 and the phase is red, so the first component write after reset lands in the red of entry 0.
- R2: A write to byte offset 0x0 with all four byte enables set loads the pointer from write data bits 31:24 and sets the phase to red.
- R3: A write to byte offset 0x4 with all four byte enables set stores write data bits 31:24 into one component of the entry the pointer selects. The target is red in phase red, green in phase green and blue in phase blue, and the phase advances red to green to blue.
- R4: After a blue write the pointer increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: Writes to any offset other than 0x0 and 0x4 (0x8, 0xC, or a non-word-aligned offset) change no entry, the pointer or the phase, and raise no change pulse.
- R6: A write whose byte enables are not all ones is ignored in the same way as in R5.
- R7: The read data output is zero at all times.
- R8: lookupRgb carries {red, green, blue} in bits 23:16, 15:8 and 7:0 of the entry named by lookupIdx at the previous clock edge, read from the table as it stood before that edge. A component written at an edge is seen by a lookup sampled at the following edge.
- R9: entryChanged is high for exactly the one cycle after each accepted component write, and low otherwise.
- R10: A pointer write between component writes restarts the sequence: the next component write goes to red again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset within the register window |
| regBe | input | 4 | Byte enables of the write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, always zero |
| lookupIdx | input | 8 | Pixel code to look up |
| lookupRgb | output | 24 | Color of the code presented one edge earlier |
| entryChanged | output | 1 | One-cycle pulse after each component write |

## Verification
The assertions assume that at most one register write is presented per cycle and that regAddr, regBe and regWe hold stable values at each sampled edge. They also assume that lookupIdx changes only at clock edges, so a held index together with no component write implies a held color. The stimulus drives every input on the falling edge and issues one write per cycle. It deliberately sends the ignored offsets and partial byte enables singly, so that a change pulse seen after any of them can only come from a decode fault.

// File: rtl/palette_pkg.sv
`timescale 1ns/1ps
package palette_pkg;
  localparam int COMP_W = 8;
  localparam int IDX_W  = 8;
  localparam int NCOMP  = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  typedef struct packed {
    logic              setIdx;
    logic              stepIdx;
    logic [NCOMP-1:0]  compWe;
    logic [COMP_W-1:0] value;
  } palStrobe_t;
endpackage

// File: rtl/palette_ctrl.sv
`timescale 1ns/1ps
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_OFF  = 0,
  parameter int DATA_OFF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W/8-1:0] regBe,
  input  logic [DATA_W-1:0] regWdata,
  output palStrobe_t        strobe
);
  localparam int BE_W = DATA_W / 8;

  phase_t phase, phaseNext;
  logic   fullWord, hitIdx, hitData;

  assign fullWord = regWe && (regBe == {BE_W{1'b1}});
  assign hitIdx   = fullWord && (regAddr == ADDR_W'(IDX_OFF));
  assign hitData  = fullWord && (regAddr == ADDR_W'(DATA_OFF));

  always_comb begin
    phaseNext = phase;
    if (hitIdx) begin
      phaseNext = PH_RED;
    end else if (hitData) begin
      unique case (phase)
        PH_RED:  phaseNext = PH_GRN;
        PH_GRN:  phaseNext = PH_BLU;
        default: phaseNext = PH_RED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_RED;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe         = '0;
    strobe.value   = regWdata[DATA_W-1 -: COMP_W];
    strobe.setIdx  = hitIdx;
    if (hitData) begin
      unique case (phase)
        PH_RED:  strobe.compWe = 3'b100;
        PH_GRN:  strobe.compWe = 3'b010;
        default: begin
          strobe.compWe  = 3'b001;
          strobe.stepIdx = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/palette_store.sv
`timescale 1ns/1ps
module palette_store
  import palette_pkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  palStrobe_t              strobe,
  input  logic [IDX_W-1:0]        lookupIdx,
  output logic [NCOMP*COMP_W-1:0] lookupRgb,
  output logic                    entryChanged
);
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr          <= '0;
      entryChanged <= 1'b0;
    end else begin
      entryChanged <= |strobe.compWe;
      if (strobe.setIdx)       ptr <= strobe.value[IDX_W-1:0];
      else if (strobe.stepIdx) ptr <= ptr + 1'b1;
    end
  end

  // one table per component; bit 2 of compWe is red, bit 0 is blue
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [COMP_W-1:0] tab [ENTRIES];
    logic [COMP_W-1:0] rdReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) begin
          tab[e] <= (e == ENTRIES - 1) ? {COMP_W{1'b1}} : '0;
        end
        rdReg <= '0;
      end else begin
        rdReg <= tab[lookupIdx];
        if (strobe.compWe[c]) tab[ptr] <= strobe.value;
      end
    end

    assign lookupRgb[c*COMP_W +: COMP_W] = rdReg;
  end
endmodule

// File: rtl/palette_dac.sv
`timescale 1ns/1ps
module palette_dac
  import palette_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_OFF  = 0,
  parameter int DATA_OFF = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W/8-1:0]     regBe,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  input  logic [IDX_W-1:0]        lookupIdx,
  output logic [NCOMP*COMP_W-1:0] lookupRgb,
  output logic                    entryChanged
);
  palStrobe_t strobe;

  assign regRdata = '0;

  palette_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_OFF(IDX_OFF), .DATA_OFF(DATA_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regBe(regBe), .regWdata(regWdata), .strobe(strobe)
  );

  palette_store #(.ENTRIES(1 << IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupIdx(lookupIdx),
    .lookupRgb(lookupRgb), .entryChanged(entryChanged)
  );
endmodule

// File: rtl/palette_dac_chk.sv
`timescale 1ns/1ps
module palette_dac_chk
  import palette_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int DATA_OFF = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regWe,
  input logic [ADDR_W-1:0]       regAddr,
  input logic [DATA_W/8-1:0]     regBe,
  input logic [DATA_W-1:0]       regWdata,
  input logic [DATA_W-1:0]       regRdata,
  input logic [IDX_W-1:0]        lookupIdx,
  input logic [NCOMP*COMP_W-1:0] lookupRgb,
  input logic                    entryChanged
);
  logic dataAcc;
  assign dataAcc = regWe && (regBe == '1) && (regAddr == ADDR_W'(DATA_OFF));

  AST_WRITE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc |=> entryChanged); // R9
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    entryChanged |-> $past(dataAcc)); // R9
  AST_OTHER_OFFSET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr != ADDR_W'(DATA_OFF)) |=> !entryChanged); // R5
  AST_PARTIAL_BE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regBe != '1) |=> !entryChanged); // R6
  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(dataAcc) && $stable(lookupIdx)) |=> $stable(lookupRgb)); // R8
endmodule

bind palette_dac palette_dac_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_OFF(DATA_OFF)
) u_chk (.*);

// File: tb/palette_dac_bench.sv
`timescale 1ns/1ps
module palette_dac_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [3:0]  regBe = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  lookupIdx = '0;
  logic [23:0] lookupRgb;
  logic        entryChanged;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [23:0] mTab [256];
  logic [7:0]  mPtr;
  int          mPhase;

  logic [23:0] expQ [$];
  logic [7:0]  idxQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  palette_dac u_palette_dac (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int e = 0; e < 256; e++) mTab[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
    mPtr = 0;
    mPhase = 0;
  endtask

  // driver: one write per call; pulse is checked one cycle later (R9)
  task automatic busWr(input logic [3:0] addr, input logic [3:0] be, input logic [7:0] val);
    bit dataHit;
    dataHit = 0;
    @(negedge clk);
    regWe = 1'b1; regAddr = addr; regBe = be; regWdata = {val, 24'h5A_C3_96};
    if (be == 4'hF && addr == 4'h0) begin
      mPtr = val; mPhase = 0;
    end else if (be == 4'hF && addr == 4'h4) begin
      dataHit = 1;
      mTab[mPtr][(2 - mPhase)*8 +: 8] = val;
      if (mPhase == 2) begin mPhase = 0; mPtr = mPtr + 1; end
      else mPhase++;
    end
    @(negedge clk);
    regWe = 1'b0; regBe = '0;
    check("R9 change pulse", {31'd0, entryChanged}, {31'd0, dataHit});
    check("R7 read data", regRdata, 32'h0);
  endtask

  task automatic lookupChk(input logic [7:0] idx, input string tag);
    @(negedge clk);
    lookupIdx = idx;
    idxQ.push_back(idx);
    expQ.push_back(mTab[idx]);
    tagQ.push_back(tag);
  endtask

  // monitor: scoreboard pops one expected colour per cycle
  initial begin
    forever begin
      @(posedge clk);
      if (expQ.size() > 0) begin
        logic [23:0] e;
        logic [7:0]  i;
        string       t;
        #1;
        e = expQ.pop_front(); i = idxQ.pop_front(); t = tagQ.pop_front();
        checks++;
        if (lookupRgb !== e) begin
          errors++;
          $display("FAIL %s entry %0d actual=%h expected=%h", t, i, lookupRgb, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {31'd0, entryChanged}, 32'd0);
    check("R7 read data after reset", regRdata, 32'h0);

    // R1: reset contents
    for (int e = 0; e < 256; e++) lookupChk(8'(e), "R1 reset entry");

    // R1: first component write after reset lands in red of entry 0
    busWr(4'h4, 4'hF, 8'h7E);
    lookupChk(8'd0, "R1 first write to red of entry 0");

    // R2/R3: program entry 5
    busWr(4'h0, 4'hF, 8'd5);
    busWr(4'h4, 4'hF, 8'h12);
    busWr(4'h4, 4'hF, 8'h34);
    busWr(4'h4, 4'hF, 8'h56);
    lookupChk(8'd5, "R3 red green blue order");
    lookupChk(8'd4, "R2 neighbour untouched");

    // R4: stream continues into entry 6
    busWr(4'h4, 4'hF, 8'hA1);
    busWr(4'h4, 4'hF, 8'hB2);
    busWr(4'h4, 4'hF, 8'hC3);
    lookupChk(8'd6, "R4 auto increment");

    // R4: wrap from 255 to 0
    busWr(4'h0, 4'hF, 8'd255);
    busWr(4'h4, 4'hF, 8'h01);
    busWr(4'h4, 4'hF, 8'h02);
    busWr(4'h4, 4'hF, 8'h03);
    busWr(4'h4, 4'hF, 8'hEE);
    lookupChk(8'd255, "R4 last entry");
    lookupChk(8'd0, "R4 wrap to entry 0");

    // R10: pointer write mid-sequence restarts at red
    busWr(4'h0, 4'hF, 8'd10);
    busWr(4'h4, 4'hF, 8'h11);
    busWr(4'h4, 4'hF, 8'h22);
    busWr(4'h0, 4'hF, 8'd10);
    busWr(4'h4, 4'hF, 8'h99);
    lookupChk(8'd10, "R10 restart at red");

    // R5: ignored offsets; next data write must hit green of entry 10
    busWr(4'h8, 4'hF, 8'h40);
    busWr(4'hC, 4'hF, 8'h41);
    busWr(4'h1, 4'hF, 8'h42);
    busWr(4'h5, 4'hF, 8'h43);
    lookupChk(8'd10, "R5 ignored offsets leave entry");
    busWr(4'h4, 4'hF, 8'h77);
    lookupChk(8'd10, "R5 phase unchanged by ignored writes");

    // R6: partial byte enables; phase stays at blue, pointer at 10
    busWr(4'h4, 4'h8, 8'h50);
    busWr(4'h0, 4'h7, 8'd40);
    busWr(4'h4, 4'h0, 8'h51);
    lookupChk(8'd10, "R6 partial write ignored");
    busWr(4'h4, 4'hF, 8'h88);
    lookupChk(8'd10, "R6 blue after partial writes");
    lookupChk(8'd11, "R6 pointer stepped past 10");

    // R8: write visibility timing on a held lookup index
    busWr(4'h0, 4'hF, 8'd20);
    busWr(4'h4, 4'hF, 8'h11);
    busWr(4'h4, 4'hF, 8'h22);
    @(negedge clk);
    lookupIdx = 8'd20;
    regWe = 1'b1; regAddr = 4'h4; regBe = 4'hF; regWdata = 32'h3300_0000;
    @(negedge clk);
    regWe = 1'b0; regBe = '0;
    check("R8 same edge sees old entry", {8'd0, lookupRgb}, {8'd0, 24'h112200});
    check("R9 pulse on blue", {31'd0, entryChanged}, 32'd1);
    @(negedge clk);
    check("R8 next edge sees new entry", {8'd0, lookupRgb}, {8'd0, 24'h112233});
    check("R9 pulse lasts one cycle", {31'd0, entryChanged}, 32'd0);
    mTab[20] = 24'h112233; mPtr = 21; mPhase = 0;

    // back-to-back mixed lookups
    lookupChk(8'd6, "R8 mixed lookup");
    lookupChk(8'd255, "R8 mixed lookup");
    lookupChk(8'd20, "R8 mixed lookup");
    lookupChk(8'd3, "R8 mixed lookup");

    repeat (3) @(negedge clk);
    check("R7 read data at end", regRdata, 32'h0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule